// File: doc/BRIEF.md
# Transmit Interpacket Gap Timer

This block decides when a MAC transmitter may start its next frame. It measures the idle time on the line since the most recent activity and asserts a transmit grant once the required gap has passed and a transmit request is pending. It knows two kinds of gap. The first follows a frame this station sent itself and is signalled by an end-of-transmission pulse. The second follows a period in which carrier from another station was present on the medium.

Each kind of gap has its own 7-bit programmable field, and each field adds to a fixed built-in latency. The own-frame gap lasts `B2B_LAT + field` clocks, which is 3 + field by default. The carrier-deferred gap lasts `DEF_LAT + field` clocks, which is 6 + field by default. The larger built-in latency of the second gap absorbs the synchronizer stages that the asynchronous carrier-sense input passes through. A gap field is captured when its gap starts, so a field written during a gap only affects later gaps. After reset the block behaves as if its own frame had just ended, and it uses a built-in field value of 15h.

Top module: `tx_gap_timer`

## Requirements
- R1: While reset is asserted the grant is low. With a request held high from reset, the grant first rises on the rising edge numbered `B2B_LAT + RST_B2B_GAP` after reset release, counting the first edge with reset high as edge 1. With the defaults this is edge 24.
- R2: If `tx_done` is sampled high at edge E0, no carrier is present and a request is pending, the grant rises at edge E0 + B2B_LAT + F. F is the value of `b2b_gap` at E0. The grant never rises at the edge that samples `tx_done` high.
- R3: Let edge A be the first edge that samples `crs_async` low after carrier was seen. The grant then rises at edge A + DEF_LAT + G. G is the value of `defer_gap` when the synchronized carrier fall is detected.
- R4: If carrier returns before a carrier-deferred gap has finished, no grant is issued, and the full gap is measured again from the next carrier fall.
- R5: While synchronized carrier sense is high, the grant does not rise.
- R6: Once asserted, the grant stays high as long as `tx_req` stays high, even if carrier rises. It falls at the first edge that samples `tx_req` low. Without a request the grant stays low.
- R7: Writing a gap field while a gap is being counted does not change that gap. The next gap uses the new value.
- R8: An end-of-transmission pulse takes priority over a carrier-deferred gap, whether that gap is pending or running. The gap is then restarted as an own-frame gap.
- R9: The field extremes work: field 00h gives the bare built-in latency, and field 7Fh gives the longest gap, 133 clocks for the carrier-deferred gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crs_async | input | 1 | Carrier sense from the line, asynchronous |
| tx_done | input | 1 | One-cycle pulse at the end of an own transmission |
| tx_req | input | 1 | Transmit request, held until the frame is done |
| b2b_gap | input | GAP_W | Gap field used after an own frame |
| defer_gap | input | GAP_W | Gap field used after foreign carrier |
| tx_grant | output | 1 | Permission to start transmitting |

## Verification
The bench builds the block with its default parameters: a 7-bit field, two synchronizer stages, and built-in latencies of 3 and 6. These values make the documented gap totals exact: 15h gives 24 clocks, 12h gives 24 clocks, 00h gives 6 clocks and 7Fh gives 133 clocks. Every scenario measures the grant edge by edge from the starting event. It can therefore detect an error of one cycle in the synchronizer depth, in the counter load value or in the grant register.

// File: rtl/tx_gap_pkg.sv
package tx_gap_pkg;

   // Which gap, if any, the counter restarts with on this edge
   typedef enum logic [1:0] {
      LD_NONE  = 2'd0,
      LD_OWN   = 2'd1,
      LD_DEFER = 2'd2
   } gap_load_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tx_gap_sync.sv
module tx_gap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("tx_gap_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic ff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= 1'b0;
            else        ff_q <= d_async;
         end
         assign q_sync = ff_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_async};
         end
         assign q_sync = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/tx_gap_counter.sv
module tx_gap_counter
   import tx_gap_pkg::*;
#(
   parameter int GAP_W     = 7,
   parameter int B2B_LAT   = 3,
   parameter int DEF_LAT   = 6,
   parameter int SYNC      = 2,
   parameter int RST_FIELD = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  gap_load_e        load_sel,
   input  logic [GAP_W-1:0] own_field,
   input  logic [GAP_W-1:0] def_field,
   output logic             rem_zero
);

   localparam int MAX_T = max2(B2B_LAT, DEF_LAT) + (1 << GAP_W) - 1;
   localparam int CNT_W = $clog2(MAX_T + 1);
   // The grant register adds one edge, and the deferred path has already spent SYNC edges.
   localparam int OWN_BASE = B2B_LAT - 1;
   localparam int DEF_BASE = DEF_LAT - SYNC - 1;
   localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(B2B_LAT - 1 + RST_FIELD);

   generate
      if (B2B_LAT < 2) begin : g_bad_own
         $error("tx_gap_counter: B2B_LAT must be at least 2");
      end
      if (DEF_LAT < SYNC + 2) begin : g_bad_def
         $error("tx_gap_counter: DEF_LAT must exceed SYNC by at least 2");
      end
      if (RST_FIELD >= (1 << GAP_W)) begin : g_bad_rst
         $error("tx_gap_counter: RST_FIELD does not fit GAP_W");
      end
   endgenerate

   logic [CNT_W-1:0] rem_q;
   logic [CNT_W-1:0] own_load;
   logic [CNT_W-1:0] def_load;

   assign own_load = CNT_W'(OWN_BASE) + CNT_W'(own_field);
   assign def_load = CNT_W'(DEF_BASE) + CNT_W'(def_field);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= RST_LOAD;
      end else begin
         case (load_sel)
            LD_OWN:   rem_q <= own_load;
            LD_DEFER: rem_q <= def_load;
            default: begin
               if (rem_q != '0) rem_q <= rem_q - CNT_W'(1);
            end
         endcase
      end
   end

   assign rem_zero = (rem_q == '0);

   // R7: a running gap steps down by one per edge, whatever the fields do
   p_step_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_sel == LD_NONE && rem_q != '0) |=> (rem_q == $past(rem_q) - CNT_W'(1)));

   // R9: the count never exceeds the longest possible gap
   p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rem_q <= CNT_W'(MAX_T));

endmodule

// File: rtl/tx_gap_grant.sv
module tx_gap_grant (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_req,
   input  logic permit,
   output logic grant
);

   logic grant_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grant_q <= 1'b0;
      else        grant_q <= tx_req && (grant_q || permit);
   end

   assign grant = grant_q;

   // R6: a released request removes the grant on the next edge
   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_req |=> !grant);

   // R6: a held request keeps the grant
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && tx_req) |=> grant);

endmodule

// File: rtl/tx_gap_timer.sv
module tx_gap_timer
   import tx_gap_pkg::*;
#(
   parameter int GAP_W       = 7,
   parameter int SYNC_STAGES = 2,
   parameter int B2B_LAT     = 3,
   parameter int DEF_LAT     = 6,
   parameter int RST_B2B_GAP = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             crs_async,
   input  logic             tx_done,
   input  logic             tx_req,
   input  logic [GAP_W-1:0] b2b_gap,
   input  logic [GAP_W-1:0] defer_gap,
   output logic             tx_grant
);

   logic      crs_s;
   logic      crs_prev_q;
   logic      def_start;
   logic      rem_zero;
   logic      permit;
   gap_load_e load_sel;

   tx_gap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (crs_async),
      .q_sync  (crs_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) crs_prev_q <= 1'b0;
      else        crs_prev_q <= crs_s;
   end

   assign def_start = crs_prev_q && !crs_s;

   // R8: own end-of-frame beats a carrier fall on the same edge
   always_comb begin
      if (tx_done)        load_sel = LD_OWN;
      else if (def_start) load_sel = LD_DEFER;
      else                load_sel = LD_NONE;
   end

   tx_gap_counter #(
      .GAP_W     (GAP_W),
      .B2B_LAT   (B2B_LAT),
      .DEF_LAT   (DEF_LAT),
      .SYNC      (SYNC_STAGES),
      .RST_FIELD (RST_B2B_GAP)
   ) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_sel  (load_sel),
      .own_field (b2b_gap),
      .def_field (defer_gap),
      .rem_zero  (rem_zero)
   );

   assign permit = rem_zero && !crs_s && !crs_prev_q && !tx_done;

   tx_gap_grant u_grant (
      .clk    (clk),
      .rst_n  (rst_n),
      .tx_req (tx_req),
      .permit (permit),
      .grant  (tx_grant)
   );

   // R5: synchronized carrier blocks a new grant
   p_carrier_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      crs_s |=> !$rose(tx_grant));

   // R2: the edge that samples end-of-frame never opens the grant
   p_done_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> !$rose(tx_grant));

   // R2, R3: a grant only opens after the gap counter has run out
   p_grant_after_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_grant) |-> $past(rem_zero));

endmodule

// File: tb/tx_gap_timer_bench.sv
module tx_gap_timer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int GAP_W      = 7;
   localparam int B2B_LAT    = 3;
   localparam int DEF_LAT    = 6;
   localparam int RST_GAP    = 21;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             crs_async = 1'b0;
   logic             tx_done = 1'b0;
   logic             tx_req = 1'b0;
   logic [GAP_W-1:0] b2b_gap = 7'h15;
   logic [GAP_W-1:0] defer_gap = 7'h12;
   logic             tx_grant;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tx_gap_timer #(
      .GAP_W(GAP_W), .SYNC_STAGES(2), .B2B_LAT(B2B_LAT),
      .DEF_LAT(DEF_LAT), .RST_B2B_GAP(RST_GAP)
   ) u_tx_gap_timer (
      .clk(clk), .rst_n(rst_n), .crs_async(crs_async), .tx_done(tx_done),
      .tx_req(tx_req), .b2b_gap(b2b_gap), .defer_gap(defer_gap),
      .tx_grant(tx_grant)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // The caller drives the starting event on a negedge. The result counts
   // rising edges, where the edge that samples the event is number 1.
   task automatic wait_grant(output int n, input int chg_at, input logic [GAP_W-1:0] chg_val);
      n = 0;
      while (1) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         tx_done = 1'b0;
         if (n == chg_at) b2b_gap = chg_val;
         if (tx_grant || n > 400) break;
      end
   endtask

   task automatic release_req();
      @(negedge clk);
      tx_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(tx_grant == 1'b0, "R6 release", tx_grant, 0);
   endtask

   task automatic t_reset();
      int n;
      tx_req = 1'b1;
      repeat (3) @(negedge clk);
      check(tx_grant == 1'b0, "R1 in reset", tx_grant, 0);
      rst_n = 1'b1;
      wait_grant(n, -1, '0);
      check(n == B2B_LAT + RST_GAP, "R1 first grant edge", n, B2B_LAT + RST_GAP);
   endtask

   task automatic t_own(input logic [GAP_W-1:0] f, input string req);
      int n;
      release_req();
      b2b_gap = f;
      tx_req  = 1'b1;
      tx_done = 1'b1;
      wait_grant(n, -1, '0);
      check(n == B2B_LAT + int'(f) + 1, req, n, B2B_LAT + int'(f) + 1);
   endtask

   task automatic carrier_on();
      tx_req = 1'b0;
      crs_async = 1'b1;
      repeat (4) @(negedge clk);
      tx_req = 1'b1;
      repeat (4) @(negedge clk);
      check(tx_grant == 1'b0, "R5 carrier present", tx_grant, 0);
   endtask

   task automatic t_defer(input logic [GAP_W-1:0] g, input bit restart, input string req);
      int n;
      release_req();
      defer_gap = g;
      carrier_on();
      crs_async = 1'b0;
      if (restart) begin
         repeat (8) @(negedge clk);
         check(tx_grant == 1'b0, "R4 early in gap", tx_grant, 0);
         crs_async = 1'b1;
         repeat (5) @(negedge clk);
         check(tx_grant == 1'b0, "R4 R5 carrier back", tx_grant, 0);
         crs_async = 1'b0;
      end
      wait_grant(n, -1, '0);
      check(n == DEF_LAT + int'(g) + 1, req, n, DEF_LAT + int'(g) + 1);
   endtask

   task automatic t_hold();
      crs_async = 1'b1;
      repeat (5) @(negedge clk);
      check(tx_grant == 1'b1, "R6 hold under carrier", tx_grant, 1);
      crs_async = 1'b0;
      repeat (3) @(negedge clk);
      tx_req = 1'b0;
      @(negedge clk);
      check(tx_grant == 1'b0, "R6 drop after release", tx_grant, 0);
      repeat (40) @(negedge clk);
      check(tx_grant == 1'b0, "R6 no grant without request", tx_grant, 0);
   endtask

   task automatic t_midwrite();
      int n;
      release_req();
      b2b_gap = 7'h10;
      tx_req  = 1'b1;
      tx_done = 1'b1;
      wait_grant(n, 5, 7'h40);
      check(n == B2B_LAT + 16 + 1, "R7 write during gap ignored", n, B2B_LAT + 17);
      release_req();
      tx_req  = 1'b1;
      tx_done = 1'b1;
      wait_grant(n, -1, '0);
      check(n == B2B_LAT + 64 + 1, "R7 new value on next gap", n, B2B_LAT + 65);
   endtask

   task automatic t_override();
      int n;
      release_req();
      defer_gap = 7'h12;
      b2b_gap   = 7'h05;
      carrier_on();
      crs_async = 1'b0;
      repeat (5) @(negedge clk);
      tx_done = 1'b1;
      wait_grant(n, -1, '0);
      check(n == B2B_LAT + 5 + 1, "R8 own frame restarts gap", n, B2B_LAT + 6);
   endtask

   initial begin
      t_reset();
      t_own(7'h15, "R2 own gap 15h");
      t_own(7'h10, "R2 own gap 10h");
      t_own(7'h00, "R9 own gap 00h");
      t_defer(7'h12, 1'b0, "R3 deferred gap 12h");
      t_hold();
      t_defer(7'h20, 1'b0, "R3 deferred gap 20h");
      t_defer(7'h7F, 1'b0, "R9 deferred gap 7Fh");
      t_defer(7'h12, 1'b1, "R4 restarted gap");
      t_midwrite();
      t_override();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule